// File: doc/BRIEF.md
# Ethernet PHY Reset and Identification Sequencer

This block brings one Ethernet PHY out of reset and works out what kind of PHY it is. A pulse on `start` latches a 5-bit PHY address. The block then runs a fixed series of register transactions on a simple request/acknowledge port. An external management-bus master, which lies outside the block, carries out each transaction on the wire.

The block first reads the basic control register. It writes the value back with reset set and isolation cleared. It then waits a settling time and polls the control register at fixed intervals until the reset bit clears. If the reset bit stays set for the whole poll budget, the block stops with an error. When reset finishes, the block takes the PHY out of isolation if needed. It then reads the two identifier registers and forms a 32-bit identifier.

The identifier is checked against a short, ordered table in which each entry has its own mask. A catch-all last entry always matches. The block reports the matched class index and a default capability mask for that class. All waits are counted in clock cycles: each wait is the microsecond count multiplied by a cycles-per-microsecond parameter.

Top module: `phy_bringup_seq`

## Requirements
- R1: A `start` pulse is accepted only while the block is not busy. Every request carries the `phy_addr` value latched by the accepted pulse. A `start` pulse while busy changes neither the address nor the sequence.
- R2: The first transaction reads register 0. The second transaction writes register 0 with the read value, bit 15 set, bit 10 cleared and all other bits unchanged.
- R3: Counting from the clock edge that accepts the reset write, the first poll request rises after exactly SETTLE_US*CYC_PER_US more edges. Counting from the edge that accepts a poll read that still shows bit 15 set, the next poll request rises after exactly POLL_GAP_US*CYC_PER_US more edges. No request is raised during either wait.
- R4: Polling reads register 0 and ends at the first read with bit 15 clear. There are never more than POLL_LIMIT poll reads.
- R5: If POLL_LIMIT poll reads all show bit 15 set, `error` goes to 1 and `done` stays 0. No further request is issued, and the identifier registers are never read.
- R6: After a successful poll, if the last poll read had bit 10 set, one write to register 0 follows. That write carries the read value with bit 10 cleared. If bit 10 was clear, no such write is issued.
- R7: After reset completes, register 2 and then register 3 are read. The identifier is {reg2, reg3} with bits 3:0 forced to zero.
- R8: Class 0 (gigabit) is reported when (id & 0x000FFFF0) == 0x000FC410. Otherwise class 1 (generic) is reported. Entries are tried in order.
- R9: `cap_mask` bits are: 0 = 10 half, 1 = 10 full, 2 = 100 half, 3 = 100 full, 4 = 1000 half, 5 = 1000 full, 6 = autonegotiation. Class 0 gives 0x7F and class 1 gives 0x4F. While `done` is 0, `cap_mask` is 0.
- R10: After reset, `done`, `error`, `busy` and `acc_req` are 0. `done` and `error` are levels that hold until the next accepted `start`. In the done and error states no request is issued.
- R11: A transaction completes in a cycle where `acc_req` and `acc_ack` are both 1. While `acc_req` is 1 and `acc_ack` is 0, the request stays up and its fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a reset and identify run |
| phy_addr | input | 5 | PHY address, latched on an accepted start |
| acc_req | output | 1 | Register transaction request |
| acc_write | output | 1 | 1 = write, 0 = read |
| acc_phy | output | 5 | PHY address of the transaction |
| acc_reg | output | 5 | Register address of the transaction |
| acc_wdata | output | 16 | Write data |
| acc_ack | input | 1 | Transaction completes this cycle |
| acc_rdata | input | 16 | Read data, valid with `acc_ack` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished and the PHY was identified |
| error | output | 1 | Reset poll budget ran out |
| phy_class | output | 1 | Matched table entry index |
| cap_mask | output | 7 | Default capability mask of the class |

## Verification
Randomised runs vary four things: the number of busy poll reads (from zero up to past the limit), a stuck isolation bit, the starting control value and the response latency. Together these separate a timeout from success on the last allowed poll, and an isolation write from its absence. They also show whether unrelated control bits survive the read-modify-write. Identifier patterns include exact gigabit codes with random don't-care bits and near misses in a single nibble of either register. Near misses show whether the mask covers the right bits and whether the fallback is chosen. Directed runs measure the settle and poll-gap wait times and send a second start with a different address mid-run.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  localparam int REG_CTL = 0;
  localparam int REG_ID_HI = 2;
  localparam int REG_ID_LO = 3;
  localparam int BIT_RESET = 15;
  localparam int BIT_ISOLATE = 10;

  localparam int NUM_ENTRIES = 2;
  localparam int CLS_W = 1;
  localparam int CAP_W = 7;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CTL, S_WR_RST, S_SETTLE, S_POLL_RD, S_POLL_GAP,
    S_WR_ISO, S_RD_ID1, S_RD_ID2, S_DONE, S_FAIL
  } seq_state_e;

  // control word for the reset write: isolation off, reset on
  function automatic logic [15:0] reset_ctl(input logic [15:0] v);
    logic [15:0] r;
    r = v;
    r[BIT_ISOLATE] = 1'b0;
    r[BIT_RESET] = 1'b1;
    return r;
  endfunction

  function automatic logic [15:0] unisolate_ctl(input logic [15:0] v);
    logic [15:0] r;
    r = v;
    r[BIT_ISOLATE] = 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] form_id(input logic [15:0] hi, input logic [15:0] lo);
    return {hi, lo[15:4], 4'h0};
  endfunction

  function automatic logic [31:0] entry_value(input int idx);
    case (idx)
      0: return 32'h000F_C410;
      default: return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [31:0] entry_mask(input int idx);
    case (idx)
      0: return 32'h000F_FFF0;
      default: return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic id_hits(input logic [31:0] id, input logic [31:0] val,
                                   input logic [31:0] msk);
    return (id & msk) == val;
  endfunction

  // bit0 10H, bit1 10F, bit2 100H, bit3 100F, bit4 1000H, bit5 1000F, bit6 autoneg
  function automatic logic [CAP_W-1:0] cap_for_class(input logic [CLS_W-1:0] cls);
    logic [CAP_W-1:0] base;
    base = 7'b100_1111;
    if (cls == '0) return base | 7'b011_0000;
    return base;
  endfunction

endpackage

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cycles,
  output logic             expire,
  output logic             running
);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_cycles - CNT_W'(1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expire  = run_q && (cnt_q == '0);
  assign running = run_q;

endmodule

// File: rtl/phy_id_matcher.sv
module phy_id_matcher
  import phy_seq_pkg::*;
#(
  parameter int ENTRIES = NUM_ENTRIES
) (
  input  logic [31:0]      id,
  output logic [CLS_W-1:0] cls
);

  logic [ENTRIES-1:0] hit;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign hit[g] = id_hits(id, entry_value(g), entry_mask(g));
  end

  // lowest index wins; last entry is the catch-all
  always_comb begin
    cls = CLS_W'(ENTRIES - 1);
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) cls = CLS_W'(i);
    end
  end

endmodule

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
#(
  parameter int POLL_LIMIT = 10000,
  parameter int SETTLE_CYC = 12500,
  parameter int GAP_CYC    = 1250,
  parameter int CNT_W      = 14,
  parameter int PC_W       = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [4:0]       phy_addr,
  input  logic             acc_ack,
  input  logic [15:0]      acc_rdata,
  input  logic             tmr_expire,
  output logic             acc_req,
  output logic             acc_write,
  output logic [4:0]       acc_phy,
  output logic [4:0]       acc_reg,
  output logic [15:0]      acc_wdata,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_cycles,
  output logic [31:0]      id_word,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             waiting,
  output logic             rst_wr_phase,
  output logic             iso_wr_phase,
  output logic [PC_W-1:0]  poll_count
);

  seq_state_e      state_q;
  logic [4:0]      addr_q;
  logic [15:0]     ctl_q;
  logic [15:0]     id_hi_q;
  logic [31:0]     id_q;
  logic [PC_W-1:0] poll_q;
  logic            last_poll;
  logic            poll_busy;
  logic            can_start;

  assign can_start = (state_q == S_IDLE) || (state_q == S_DONE) || (state_q == S_FAIL);
  assign last_poll = ({1'b0, poll_q} + 1'b1) == (PC_W + 1)'(POLL_LIMIT);
  assign poll_busy = acc_rdata[BIT_RESET];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      ctl_q   <= '0;
      id_hi_q <= '0;
      id_q    <= '0;
      poll_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE, S_DONE, S_FAIL: begin
          if (start) begin
            addr_q  <= phy_addr;
            poll_q  <= '0;
            state_q <= S_RD_CTL;
          end
        end
        S_RD_CTL: begin
          if (acc_ack) begin
            ctl_q   <= reset_ctl(acc_rdata);
            state_q <= S_WR_RST;
          end
        end
        S_WR_RST: if (acc_ack) state_q <= S_SETTLE;
        S_SETTLE: if (tmr_expire) state_q <= S_POLL_RD;
        S_POLL_RD: begin
          if (acc_ack) begin
            poll_q <= poll_q + PC_W'(1);
            if (!poll_busy) begin
              ctl_q   <= unisolate_ctl(acc_rdata);
              state_q <= acc_rdata[BIT_ISOLATE] ? S_WR_ISO : S_RD_ID1;
            end else if (last_poll) begin
              state_q <= S_FAIL;
            end else begin
              state_q <= S_POLL_GAP;
            end
          end
        end
        S_POLL_GAP: if (tmr_expire) state_q <= S_POLL_RD;
        S_WR_ISO: if (acc_ack) state_q <= S_RD_ID1;
        S_RD_ID1: begin
          if (acc_ack) begin
            id_hi_q <= acc_rdata;
            state_q <= S_RD_ID2;
          end
        end
        S_RD_ID2: begin
          if (acc_ack) begin
            id_q    <= form_id(id_hi_q, acc_rdata);
            state_q <= S_DONE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    acc_req   = 1'b0;
    acc_write = 1'b0;
    acc_reg   = 5'(REG_CTL);
    acc_wdata = '0;
    case (state_q)
      S_RD_CTL, S_POLL_RD: acc_req = 1'b1;
      S_WR_RST, S_WR_ISO: begin
        acc_req   = 1'b1;
        acc_write = 1'b1;
        acc_wdata = ctl_q;
      end
      S_RD_ID1: begin
        acc_req = 1'b1;
        acc_reg = 5'(REG_ID_HI);
      end
      S_RD_ID2: begin
        acc_req = 1'b1;
        acc_reg = 5'(REG_ID_LO);
      end
      default: ;
    endcase
  end

  assign tmr_load   = acc_ack && ((state_q == S_WR_RST) ||
                                  ((state_q == S_POLL_RD) && poll_busy && !last_poll));
  assign tmr_cycles = (state_q == S_WR_RST) ? CNT_W'(SETTLE_CYC) : CNT_W'(GAP_CYC);

  assign acc_phy      = addr_q;
  assign id_word      = id_q;
  assign busy         = !can_start;
  assign done         = state_q == S_DONE;
  assign error        = state_q == S_FAIL;
  assign waiting      = (state_q == S_SETTLE) || (state_q == S_POLL_GAP);
  assign rst_wr_phase = state_q == S_WR_RST;
  assign iso_wr_phase = state_q == S_WR_ISO;
  assign poll_count   = poll_q;

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter int CYC_PER_US  = 125,
  parameter int SETTLE_US   = 100,
  parameter int POLL_GAP_US = 10,
  parameter int POLL_LIMIT  = 10000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [4:0]                    phy_addr,
  output logic                          acc_req,
  output logic                          acc_write,
  output logic [4:0]                    acc_phy,
  output logic [4:0]                    acc_reg,
  output logic [15:0]                   acc_wdata,
  input  logic                          acc_ack,
  input  logic [15:0]                   acc_rdata,
  output logic                          busy,
  output logic                          done,
  output logic                          error,
  output logic [phy_seq_pkg::CLS_W-1:0] phy_class,
  output logic [phy_seq_pkg::CAP_W-1:0] cap_mask
);

  localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
  localparam int GAP_CYC    = POLL_GAP_US * CYC_PER_US;
  localparam int MAX_CYC    = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);
  localparam int PC_W       = $clog2(POLL_LIMIT + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_cycles;
  logic             tmr_expire;
  logic             tmr_running;
  logic [31:0]      id_word;
  logic [CLS_W-1:0] match_cls;
  logic             seq_waiting;
  logic             rst_wr_phase;
  logic             iso_wr_phase;
  logic [PC_W-1:0]  poll_count;

  phy_seq_ctrl #(
    .POLL_LIMIT (POLL_LIMIT),
    .SETTLE_CYC (SETTLE_CYC),
    .GAP_CYC    (GAP_CYC),
    .CNT_W      (CNT_W),
    .PC_W       (PC_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .phy_addr     (phy_addr),
    .acc_ack      (acc_ack),
    .acc_rdata    (acc_rdata),
    .tmr_expire   (tmr_expire),
    .acc_req      (acc_req),
    .acc_write    (acc_write),
    .acc_phy      (acc_phy),
    .acc_reg      (acc_reg),
    .acc_wdata    (acc_wdata),
    .tmr_load     (tmr_load),
    .tmr_cycles   (tmr_cycles),
    .id_word      (id_word),
    .busy         (busy),
    .done         (done),
    .error        (error),
    .waiting      (seq_waiting),
    .rst_wr_phase (rst_wr_phase),
    .iso_wr_phase (iso_wr_phase),
    .poll_count   (poll_count)
  );

  phy_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (tmr_load),
    .load_cycles (tmr_cycles),
    .expire      (tmr_expire),
    .running     (tmr_running)
  );

  phy_id_matcher u_match (
    .id  (id_word),
    .cls (match_cls)
  );

  assign phy_class = done ? match_cls : '0;
  assign cap_mask  = done ? cap_for_class(match_cls) : '0;

endmodule

// File: rtl/phy_bringup_seq_chk.sv
module phy_bringup_seq_chk #(
  parameter int POLL_LIMIT = 10000,
  parameter int PC_W       = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_req,
  input logic            acc_write,
  input logic [4:0]      acc_phy,
  input logic [4:0]      acc_reg,
  input logic [15:0]     acc_wdata,
  input logic            acc_ack,
  input logic            done,
  input logic            error,
  input logic            phy_class,
  input logic [6:0]      cap_mask,
  input logic            seq_waiting,
  input logic            rst_wr_phase,
  input logic            iso_wr_phase,
  input logic [PC_W-1:0] poll_count
);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_ack |=> acc_req && $stable({acc_write, acc_reg, acc_wdata, acc_phy}));

  p_quiet_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_waiting |-> !acc_req);

  p_reset_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr_phase |-> acc_req && acc_write && acc_reg == 5'd0 && acc_wdata[15] && !acc_wdata[10]);

  p_iso_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    iso_wr_phase |-> acc_req && acc_write && acc_reg == 5'd0 && !acc_wdata[10] && !acc_wdata[15]);

  p_poll_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    poll_count <= PC_W'(POLL_LIMIT));

  p_fail_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !acc_req && !done);

  p_gig_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !phy_class |-> cap_mask == 7'h7F);

  p_gen_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && phy_class |-> cap_mask == 7'h4F);

  p_idle_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> cap_mask == 7'h00);

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !acc_req && !error);

endmodule

bind phy_bringup_seq phy_bringup_seq_chk #(
  .POLL_LIMIT (POLL_LIMIT),
  .PC_W       ($clog2(POLL_LIMIT + 1))
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_req      (acc_req),
  .acc_write    (acc_write),
  .acc_phy      (acc_phy),
  .acc_reg      (acc_reg),
  .acc_wdata    (acc_wdata),
  .acc_ack      (acc_ack),
  .done         (done),
  .error        (error),
  .phy_class    (phy_class),
  .cap_mask     (cap_mask),
  .seq_waiting  (seq_waiting),
  .rst_wr_phase (rst_wr_phase),
  .iso_wr_phase (iso_wr_phase),
  .poll_count   (poll_count)
);

// File: tb/phy_bringup_seq_tb.sv
module phy_bringup_seq_tb;

  localparam int CPU    = 2;
  localparam int SET_US = 3;
  localparam int GAP_US = 2;
  localparam int LIMIT  = 5;
  localparam int SET_CYC = SET_US * CPU;
  localparam int GAP_CYC = GAP_US * CPU;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic        acc_req, acc_write;
  logic [4:0]  acc_phy, acc_reg;
  logic [15:0] acc_wdata;
  logic        acc_ack = 1'b0;
  logic [15:0] acc_rdata = '0;
  logic        busy, done, error;
  logic [0:0]  phy_class;
  logic [6:0]  cap_mask;

  phy_bringup_seq #(
    .CYC_PER_US(CPU), .SETTLE_US(SET_US), .POLL_GAP_US(GAP_US), .POLL_LIMIT(LIMIT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .phy_addr(phy_addr),
    .acc_req(acc_req), .acc_write(acc_write), .acc_phy(acc_phy), .acc_reg(acc_reg),
    .acc_wdata(acc_wdata), .acc_ack(acc_ack), .acc_rdata(acc_rdata),
    .busy(busy), .done(done), .error(error), .phy_class(phy_class), .cap_mask(cap_mask)
  );

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // PHY model state
  logic [15:0] m_ctl;
  logic        m_iso;
  int          m_busy_left;
  int          m_busy_reads;
  logic        m_iso_stuck;
  logic [15:0] m_id_hi, m_id_lo;
  int          m_lat;
  int          wcnt = 0;
  bit          seen = 0;
  logic [26:0] held;
  int          unstable = 0;

  logic        lg_wr  [64];
  logic [4:0]  lg_reg [64];
  logic [4:0]  lg_adr [64];
  logic [15:0] lg_dat [64];
  int          lg_seen[64];
  int          lg_ack [64];
  int          lg_n = 0;

  always @(negedge clk) begin
    if (acc_ack) begin
      acc_ack = 1'b0;
      wcnt = 0;
      seen = 0;
    end else if (acc_req) begin
      if (!seen) begin
        seen = 1;
        held = {acc_write, acc_reg, acc_phy, acc_wdata};
        if (lg_n < 64) lg_seen[lg_n] = cyc;
      end else if (held != {acc_write, acc_reg, acc_phy, acc_wdata}) begin
        unstable++;
      end
      if (wcnt < m_lat) wcnt++;
      else begin
        if (lg_n < 64) begin
          lg_wr[lg_n] = acc_write; lg_reg[lg_n] = acc_reg;
          lg_adr[lg_n] = acc_phy; lg_dat[lg_n] = acc_wdata; lg_ack[lg_n] = cyc;
        end
        lg_n++;
        if (acc_write) begin
          if (acc_reg == 5'd0) begin
            if (acc_wdata[15]) begin
              m_ctl = acc_wdata & 16'h7FFF;
              m_busy_left = m_busy_reads;
              m_iso = m_iso_stuck;
            end else begin
              m_ctl = acc_wdata;
              m_iso = 1'b0;
            end
          end
          acc_rdata = '0;
        end else begin
          case (acc_reg)
            5'd0: begin
              acc_rdata = m_ctl | (m_iso ? 16'h0400 : 16'h0) | (m_busy_left > 0 ? 16'h8000 : 16'h0);
              if (m_busy_left > 0) m_busy_left--;
            end
            5'd2: acc_rdata = m_id_hi;
            5'd3: acc_rdata = m_id_lo;
            default: acc_rdata = '0;
          endcase
        end
        acc_ack = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [0:0] exp_class(input logic [15:0] hi, input logic [15:0] lo);
    logic [31:0] id;
    id = {hi, lo} & 32'hFFFF_FFF0;
    return ((id & 32'h000F_FFF0) == 32'h000F_C410) ? 1'b0 : 1'b1;
  endfunction

  function automatic logic [6:0] exp_cap(input logic [0:0] c);
    return (c == 1'b0) ? 7'h7F : 7'h4F;
  endfunction

  // Runs one sequence; a second start with addr2 is sent mid-run when late_start is set
  task automatic run_case(input logic [4:0] addr, input logic [15:0] init_ctl, input int busy_reads,
                          input logic iso_stuck, input logic [15:0] hi, input logic [15:0] lo,
                          input int lat, input bit late_start, input logic [4:0] addr2);
    int n_exp, p, polls, waitc, n_before;
    logic [15:0] ctl_after, wexp;
    bit fail_exp;
    m_ctl = init_ctl; m_iso = 1'b0; m_busy_left = 0; m_busy_reads = busy_reads;
    m_iso_stuck = iso_stuck; m_id_hi = hi; m_id_lo = lo; m_lat = lat;
    lg_n = 0; unstable = 0;
    @(negedge clk);
    start = 1'b1; phy_addr = addr;
    @(negedge clk);
    start = 1'b0; phy_addr = 5'd0;
    if (late_start) begin
      repeat (3) @(negedge clk);
      start = 1'b1; phy_addr = addr2;
      @(negedge clk);
      start = 1'b0;
    end
    waitc = 0;
    while (!(done || error) && waitc < 3000) begin
      @(negedge clk);
      waitc++;
    end
    check(waitc < 3000, "R10 run finishes", waitc, 3000);
    fail_exp = busy_reads >= LIMIT;
    polls = fail_exp ? LIMIT : busy_reads + 1;
    ctl_after = init_ctl & 16'h7BFF;
    n_exp = 2 + polls + (fail_exp ? 0 : (iso_stuck ? 3 : 2));
    check(lg_n == n_exp, "R4 transaction count", lg_n, n_exp);
    for (int i = 0; i < lg_n && i < 64; i++)
      check(lg_adr[i] == addr, "R1 address", lg_adr[i], addr);
    check(!lg_wr[0] && lg_reg[0] == 5'd0, "R2 first is read of reg 0", {lg_wr[0], lg_reg[0]}, 0);
    wexp = (init_ctl | 16'h8000) & 16'hFBFF;
    check(lg_wr[1] && lg_reg[1] == 5'd0 && lg_dat[1] == wexp, "R2 reset write", lg_dat[1], wexp);
    for (int i = 0; i < polls; i++) begin
      p = 2 + i;
      check(!lg_wr[p] && lg_reg[p] == 5'd0, "R4 poll read", {lg_wr[p], lg_reg[p]}, 0);
    end
    check(unstable == 0, "R11 fields stable while waiting", unstable, 0);
    if (fail_exp) begin
      check(error && !done, "R5 error set", {error, done}, 2'b10);
      check(cap_mask == 7'h0, "R9 cap zero on error", cap_mask, 0);
    end else begin
      p = 2 + polls;
      if (iso_stuck) begin
        check(lg_wr[p] && lg_reg[p] == 5'd0 && lg_dat[p] == ctl_after, "R6 isolate write", lg_dat[p], ctl_after);
        p++;
      end else begin
        check(!lg_wr[p], "R6 no isolate write", lg_wr[p], 0);
      end
      check(!lg_wr[p] && lg_reg[p] == 5'd2, "R7 read reg 2", lg_reg[p], 2);
      check(!lg_wr[p+1] && lg_reg[p+1] == 5'd3, "R7 read reg 3", lg_reg[p+1], 3);
      check(done && !error, "R10 done set", {done, error}, 2'b10);
      check(phy_class == exp_class(hi, lo), "R8 class", phy_class, exp_class(hi, lo));
      check(cap_mask == exp_cap(exp_class(hi, lo)), "R9 cap mask", cap_mask, exp_cap(exp_class(hi, lo)));
    end
    n_before = lg_n;
    repeat (15) @(negedge clk);
    check(lg_n == n_before && (done || error) && !acc_req, "R10 levels hold, no request", lg_n, n_before);
  endtask

  initial begin
    logic [15:0] hi, lo;
    void'($urandom(32'h5EED_1234));
    m_ctl = '0; m_iso = 0; m_busy_left = 0; m_busy_reads = 0; m_iso_stuck = 0;
    m_id_hi = '0; m_id_lo = '0; m_lat = 0;
    repeat (3) @(negedge clk);
    check(!done && !error && !busy && !acc_req && cap_mask == 0, "R10 reset state",
          {done, error, busy, acc_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 timing: settle wait and poll gap, zero latency
    run_case(5'd7, 16'h1140, 1, 1'b0, 16'h0E0F, 16'hC412, 0, 0, 5'd0);
    check(lg_seen[2] - lg_ack[1] == SET_CYC + 1, "R3 settle wait", lg_seen[2] - lg_ack[1], SET_CYC + 1);
    check(lg_seen[3] - lg_ack[2] == GAP_CYC + 1, "R3 poll gap", lg_seen[3] - lg_ack[2], GAP_CYC + 1);
    // R1 start while busy is ignored
    run_case(5'd5, 16'h3100, 2, 1'b1, 16'h0000, 16'h0000, 1, 1, 5'd9);
    // R5 exact timeout, R4 success on last allowed poll
    run_case(5'd3, 16'hFFFF, LIMIT, 1'b0, 16'h000F, 16'hC410, 2, 0, 5'd0);
    run_case(5'd3, 16'h8400, LIMIT - 1, 1'b1, 16'h000F, 16'hC410, 0, 0, 5'd0);
    // R8 near misses and ignored high bits
    run_case(5'd1, 16'h0000, 0, 1'b0, 16'h000E, 16'hC410, 0, 0, 5'd0);
    run_case(5'd1, 16'h0000, 0, 1'b0, 16'h000F, 16'hC420, 0, 0, 5'd0);
    run_case(5'd1, 16'h0000, 0, 1'b0, 16'hFFFF, 16'hC41F, 3, 0, 5'd0);
    // constrained random
    for (int k = 0; k < 24; k++) begin
      if ($urandom_range(1, 0) == 1) begin
        hi = {16'($urandom) | 16'h000F};
        lo = {12'hC41, 4'($urandom)};
      end else begin
        hi = 16'($urandom); lo = 16'($urandom);
      end
      run_case(5'($urandom), 16'($urandom), $urandom_range(LIMIT + 1, 0), 1'($urandom),
               hi, lo, $urandom_range(3, 0), 0, 5'd0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule